// File: doc/BRIEF.md
# Transmit Control-Character Encoder

This block is the parallel-to-serial transmit front end of a serial backplane link. It captures an 8-bit byte and four control inputs once per character period. It then decides whether the character is ordinary data, a comma character for framing, or one of a few special control characters. The chosen character is encoded with an 8b/10b code that tracks running disparity. The resulting 10-bit symbol is shifted out one bit per bit-rate enable, with ten enables to a character.

The controls work as a small priority table. The special-character request has priority over the framing strobe. When it is set, a 2-bit selector chooses one of two things: a special character built from the byte value itself, or one of three fixed control characters. Without the special-character request, the framing strobe sends a comma. With neither control set, the byte goes out as data. A wrap select sends the serial stream to a separate loopback output for the receiver and holds the line output at zero.

Top module: `txk_serial_encoder`

## Requirements
- R1: While reset (active low, synchronous) is asserted, `line_o`, `wrap_o` and `byte_take` are 0 and running disparity becomes negative. The first symbol sent after reset is the negative-disparity comma K28.5, 0011111010 written in the order a, b, c, d, e, i, f, g, h, j.
- R2: `byte_take` rises on exactly every tenth cycle in which `bit_en` is high, and only in such a cycle. The inputs are captured at that edge, and their symbol starts on the line at the following `byte_take` edge.
- R3: With `k_gen`=0 and `comma_req`=0, the byte is sent as data character D.x.y, where x = byte[4:0] and y = byte[7:5]. Its 10-bit code is the standard 8b/10b code for the current running disparity.
- R4: With `k_gen`=0 and `comma_req`=1, K28.5 (byte value 0xBC as a control character) is sent whatever the byte is, in the version selected by running disparity.
- R5: With `k_gen`=1 and `k_pick`=00, the byte value is sent as the control character with that value: K28.0 to K28.7, K23.7, K27.7, K29.7 or K30.7. `comma_req` is ignored.
- R6: With `k_gen`=1, `k_pick`=01 sends K28.1, 10 sends K28.3 and 11 sends K28.7, whatever the byte and `comma_req` are.
- R7: Each symbol is the positive or negative version chosen by the running disparity. After every symbol, the line's running sum of ones minus zeros is back at one of the two legal boundary values, and inside a symbol it never leaves a band of six.
- R8: Bit 0 of the 10-bit code (code bit a, which carries byte bit 0) goes out first and j goes out last. The line changes only after a cycle with `bit_en` high.
- R9: With `wrap_en`=1, `line_o` is held at 0 and `wrap_o` carries the serial stream. With `wrap_en`=0, `wrap_o` is 0.
- R10: The serial stream never contains more than five equal consecutive bits, and the comma produces a run of exactly five.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable, one serial bit per enabled cycle |
| tx_byte | input | 8 | Data byte, bit 0 sent first |
| comma_req | input | 1 | Framing strobe, sends K28.5 |
| k_gen | input | 1 | Special-character request |
| k_pick | input | 2 | Special-character selector |
| wrap_en | input | 1 | Route stream to loopback output |
| byte_take | output | 1 | High in the cycle whose edge captures the inputs |
| line_o | output | 1 | External serial output |
| wrap_o | output | 1 | Loopback serial output to the receiver |

## Verification
If the running-disparity register holds the wrong value, the next unbalanced character leaves with the wrong polarity. That shows on the line within one character time of its load edge, and the line's running sum lands on an illegal boundary value at the end of that symbol. A phase-counter fault shows at once as a `byte_take` period other than ten enabled cycles. A wrong shift order or wrong sub-block table shows as a mismatched 10-bit word the first time that byte value is sent. The bench therefore sweeps every byte value under both disparities and every control combination.

// File: rtl/txk_pkg.sv
// Shared constants and types for the transmit control-character encoder.
// Assumes the 8b/10b code: 8-bit bytes, 10-bit symbols split 6+4.
package txk_pkg;
    localparam int BYTE_W = 8;
    localparam int SYM_W  = 10;
    localparam int SIX_W  = 6;
    localparam int FOUR_W = 4;

    // Selector values for the special-character request
    typedef enum logic [1:0] {
        KPICK_BYTE = 2'b00,
        KPICK_K281 = 2'b01,
        KPICK_K283 = 2'b10,
        KPICK_K287 = 2'b11
    } kpick_e;

    // Byte values of the fixed control characters (y in [7:5], x in [4:0])
    localparam logic [BYTE_W-1:0] K28_1_V = 8'h3C;
    localparam logic [BYTE_W-1:0] K28_3_V = 8'h7C;
    localparam logic [BYTE_W-1:0] K28_5_V = 8'hBC;
    localparam logic [BYTE_W-1:0] K28_7_V = 8'hFC;

    // One character request as captured at the byte edge
    typedef struct packed {
        logic              comma;
        logic              kgen;
        logic [1:0]        kpick;
        logic [BYTE_W-1:0] data;
    } txk_ctl_t;
endpackage

// File: rtl/txk_phase.sv
// Character phase counter: counts bit enables and flags the last bit
// of each character, the edge at which a new symbol is loaded.
// Assumes sym_load is only meaningful together with bit_en.
module txk_phase #(
    parameter int SYM_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    output logic sym_load
);
    localparam int PW = $clog2(SYM_BITS);
    localparam logic [PW-1:0] LAST = PW'(SYM_BITS - 1);

    logic [PW-1:0] ph_q;

    // Advance the bit position on each enable, wrapping after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (bit_en) begin
            ph_q <= (ph_q == LAST) ? '0 : ph_q + PW'(1);
        end
    end

    // Load strobe on the enabled cycle of the last bit position
    always_comb begin
        sym_load = bit_en && (ph_q == LAST);
    end
endmodule

// File: rtl/txk_char_map.sv
// Control priority table: picks the byte value and the control flag of
// the character to encode. The special-character request beats the
// framing strobe, which beats plain data.
module txk_char_map
    import txk_pkg::*;
(
    input  txk_ctl_t          ctl,
    output logic              is_k,
    output logic [BYTE_W-1:0] char_v
);
    // Resolve the control inputs into one character
    always_comb begin
        is_k   = 1'b0;
        char_v = ctl.data;
        if (ctl.kgen) begin
            is_k = 1'b1;
            case (kpick_e'(ctl.kpick))
                KPICK_BYTE: char_v = ctl.data;
                KPICK_K281: char_v = K28_1_V;
                KPICK_K283: char_v = K28_3_V;
                default:    char_v = K28_7_V;
            endcase
        end else if (ctl.comma) begin
            is_k   = 1'b1;
            char_v = K28_5_V;
        end
    end
endmodule

// File: rtl/txk_encoder.sv
// 8b/10b encoder with a running-disparity register. The sub-block tables
// hold the negative-disparity forms; the positive forms are complements.
// Output symbol has code bit a at bit 0 and j at bit 9.
// Assumes adv is high exactly on the edges where a symbol is consumed.
module txk_encoder
    import txk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              is_k,
    input  logic [BYTE_W-1:0] char_v,
    output logic [SYM_W-1:0]  sym
);
    logic              rd_q;      // 1 = positive running disparity
    logic              rd_mid;
    logic              rd_nxt;
    logic              k28;
    logic              alt7;
    logic [4:0]        low5;
    logic [2:0]        hi3;
    logic [SIX_W-1:0]  six_m;
    logic [SIX_W-1:0]  six;
    logic [FOUR_W-1:0] four_m;
    logic [FOUR_W-1:0] four;

    // Negative-disparity 6-bit sub-block, written a..i from MSB to LSB
    function automatic logic [SIX_W-1:0] six_neg(input logic [4:0] v);
        case (v)
            5'd0:  six_neg = 6'b100111;  5'd1:  six_neg = 6'b011101;
            5'd2:  six_neg = 6'b101101;  5'd3:  six_neg = 6'b110001;
            5'd4:  six_neg = 6'b110101;  5'd5:  six_neg = 6'b101001;
            5'd6:  six_neg = 6'b011001;  5'd7:  six_neg = 6'b111000;
            5'd8:  six_neg = 6'b111001;  5'd9:  six_neg = 6'b100101;
            5'd10: six_neg = 6'b010101;  5'd11: six_neg = 6'b110100;
            5'd12: six_neg = 6'b001101;  5'd13: six_neg = 6'b101100;
            5'd14: six_neg = 6'b011100;  5'd15: six_neg = 6'b010111;
            5'd16: six_neg = 6'b011011;  5'd17: six_neg = 6'b100011;
            5'd18: six_neg = 6'b010011;  5'd19: six_neg = 6'b110010;
            5'd20: six_neg = 6'b001011;  5'd21: six_neg = 6'b101010;
            5'd22: six_neg = 6'b011010;  5'd23: six_neg = 6'b111010;
            5'd24: six_neg = 6'b110011;  5'd25: six_neg = 6'b100110;
            5'd26: six_neg = 6'b010110;  5'd27: six_neg = 6'b110110;
            5'd28: six_neg = 6'b001110;  5'd29: six_neg = 6'b101110;
            5'd30: six_neg = 6'b011110;  default: six_neg = 6'b101011;
        endcase
    endfunction

    // Negative-disparity 4-bit sub-block, written f..j from MSB to LSB
    function automatic logic [FOUR_W-1:0] four_neg(input logic [2:0] v, input logic alt);
        case (v)
            3'd0: four_neg = 4'b1011;
            3'd1: four_neg = 4'b1001;
            3'd2: four_neg = 4'b0101;
            3'd3: four_neg = 4'b1100;
            3'd4: four_neg = 4'b1101;
            3'd5: four_neg = 4'b1010;
            3'd6: four_neg = 4'b0110;
            default: four_neg = alt ? 4'b0111 : 4'b1110;
        endcase
    endfunction

    // Select both sub-blocks and the disparity that follows them
    always_comb begin
        low5  = char_v[4:0];
        hi3   = char_v[7:5];
        k28   = is_k && (low5 == 5'd28);
        six_m = k28 ? 6'b001111 : six_neg(low5);
        six   = (rd_q && (($countones(six_m) != 3) || (six_m == 6'b111000))) ? ~six_m : six_m;
        if ($countones(six) > 3)      rd_mid = 1'b1;
        else if ($countones(six) < 3) rd_mid = 1'b0;
        else                          rd_mid = rd_q;
        alt7 = (hi3 == 3'd7) &&
               (is_k ||
                (!rd_mid && (low5 == 5'd17 || low5 == 5'd18 || low5 == 5'd20)) ||
                ( rd_mid && (low5 == 5'd11 || low5 == 5'd13 || low5 == 5'd14)));
        four_m = four_neg(hi3, alt7);
        four   = (rd_mid && (($countones(four_m) != 2) || (four_m == 4'b1100))) ? ~four_m : four_m;
        if (k28 && !rd_mid && (hi3 == 3'd1 || hi3 == 3'd2 || hi3 == 3'd5 || hi3 == 3'd6)) begin
            four = ~four;
        end
        if ($countones(four) > 2)      rd_nxt = 1'b1;
        else if ($countones(four) < 2) rd_nxt = 1'b0;
        else                           rd_nxt = rd_mid;
    end

    // Lay the sub-blocks out so that code bit a sits at symbol bit 0
    always_comb begin
        for (int i = 0; i < SIX_W; i++)  sym[i]         = six[SIX_W-1-i];
        for (int i = 0; i < FOUR_W; i++) sym[SIX_W + i] = four[FOUR_W-1-i];
    end

    // Running disparity register, negative after reset
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_q <= 1'b0;
        else if (adv) rd_q <= rd_nxt;
    end
endmodule

// File: rtl/txk_shifter.sv
// Serializer: loads a symbol on the load strobe and shifts it out LSB
// first on each bit enable; steers the bit to line or loopback output.
// Assumes load is only asserted together with bit_en.
module txk_shifter #(
    parameter int SYM_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                load,
    input  logic [SYM_BITS-1:0] sym,
    input  logic                wrap_en,
    output logic                line_o,
    output logic                wrap_o
);
    logic [SYM_BITS-1:0] sh_q;

    // Load a new symbol or move the next bit into position 0
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (load)    sh_q <= sym;
        else if (bit_en)  sh_q <= sh_q >> 1;
    end

    // Output steering between the line and the loopback path
    always_comb begin
        line_o = wrap_en ? 1'b0 : sh_q[0];
        wrap_o = wrap_en ? sh_q[0] : 1'b0;
    end
endmodule

// File: rtl/txk_serial_encoder.sv
// Transmit control-character encoder, top level. Captures the byte and
// controls at each character edge, encodes them during the following
// character, and serializes the symbol after the next edge.
// Assumes bit_en is synchronous to clk; ten enables make one character.
module txk_serial_encoder
    import txk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              comma_req,
    input  logic              k_gen,
    input  logic [1:0]        k_pick,
    input  logic              wrap_en,
    output logic              byte_take,
    output logic              line_o,
    output logic              wrap_o
);
    localparam txk_ctl_t CTL_RST = '{comma: 1'b1, kgen: 1'b0, kpick: 2'b00, data: '0};

    logic              sym_load;
    logic              is_k;
    logic [BYTE_W-1:0] char_v;
    logic [SYM_W-1:0]  sym;
    txk_ctl_t          ctl_q;

    txk_phase #(.SYM_BITS(SYM_W)) phase_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .sym_load (sym_load)
    );

    // Input capture stage; a comma is pending after reset
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= CTL_RST;
        else if (sym_load) ctl_q <= '{comma: comma_req, kgen: k_gen, kpick: k_pick, data: tx_byte};
    end

    txk_char_map map_i (
        .ctl    (ctl_q),
        .is_k   (is_k),
        .char_v (char_v)
    );

    txk_encoder enc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (sym_load),
        .is_k   (is_k),
        .char_v (char_v),
        .sym    (sym)
    );

    txk_shifter #(.SYM_BITS(SYM_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .load    (sym_load),
        .sym     (sym),
        .wrap_en (wrap_en),
        .line_o  (line_o),
        .wrap_o  (wrap_o)
    );

    // Expose the capture edge to the sender
    always_comb begin
        byte_take = sym_load;
    end
endmodule

// File: rtl/txk_serial_encoder_chk.sv
// Port-level checker for the transmit encoder: character period, output
// steering, hold between enables, run length and line running sum.
module txk_serial_encoder_chk #(
    parameter int SYM_BITS = 10
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic byte_take,
    input logic wrap_en,
    input logic line_o,
    input logic wrap_o
);
    localparam int CW = $clog2(SYM_BITS);

    logic [CW-1:0]     cnt_q;
    logic              started_q;
    logic              last_q;
    logic [3:0]        run_q;
    logic signed [4:0] rds_q;
    logic signed [4:0] rds_nxt;
    logic              bitv;

    // Serial bit on whichever output is active
    always_comb begin
        bitv    = line_o | wrap_o;
        rds_nxt = rds_q + (bitv ? 5'sd1 : -5'sd1);
    end

    // Enabled cycles since the last capture edge
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (bit_en) cnt_q <= byte_take ? '0 : cnt_q + CW'(1);
    end

    // Line statistics, counted from the first symbol load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            last_q    <= 1'b0;
            run_q     <= '0;
            rds_q     <= '0;
        end else begin
            if (byte_take) started_q <= 1'b1;
            if (bit_en && started_q) begin
                rds_q  <= rds_nxt;
                last_q <= bitv;
                if (bitv != last_q)      run_q <= 4'd1;
                else if (run_q != 4'd15) run_q <= run_q + 4'd1;
            end
        end
    end

    a_r2_take_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> bit_en);
    a_r2_take_period: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> (cnt_q == CW'(SYM_BITS - 1)));
    a_r9_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_en |-> !line_o);
    a_r9_wrap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_en |-> !wrap_o);
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_o | wrap_o));
    a_r10_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 4'd5);
    a_r7_boundary_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && byte_take) |-> (rds_nxt == 5'sd0 || rds_nxt == 5'sd2));
    a_r7_sum_band: assert property (@(posedge clk) disable iff (!rst_n)
        (rds_q >= -5'sd2) && (rds_q <= 5'sd4));
endmodule

bind txk_serial_encoder txk_serial_encoder_chk #(.SYM_BITS(txk_pkg::SYM_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .byte_take (byte_take),
    .wrap_en   (wrap_en),
    .line_o    (line_o),
    .wrap_o    (wrap_o)
);

// File: tb/txk_serial_encoder_tb_top.sv
`timescale 1ns/100ps
module txk_serial_encoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b1;
    logic [7:0] tx_byte = '0;
    logic       comma_req = 1'b0;
    logic       k_gen = 1'b0;
    logic [1:0] k_pick = 2'b00;
    logic       wrap_en = 1'b0;
    logic       byte_take;
    logic       line_o;
    logic       wrap_o;

    always #2.5 clk = ~clk;

    txk_serial_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_byte(tx_byte),
        .comma_req(comma_req), .k_gen(k_gen), .k_pick(k_pick), .wrap_en(wrap_en),
        .byte_take(byte_take), .line_o(line_o), .wrap_o(wrap_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic gate_mode = 1'b0;
    logic mrd = 1'b0;              // model running disparity, 1 = positive
    logic [9:0] exq[$];
    string tagq[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bit-rate enable pattern: steady, or two of every three cycles
    always @(negedge clk) begin
        cyc++;
        bit_en = gate_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // Reference 6-bit sub-block, negative form, a first (MSB)
    function automatic logic [5:0] ref6(input logic [4:0] v);
        logic [5:0] t[32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                              6'b110101, 6'b101001, 6'b011001, 6'b111000,
                              6'b111001, 6'b100101, 6'b010101, 6'b110100,
                              6'b001101, 6'b101100, 6'b011100, 6'b010111,
                              6'b011011, 6'b100011, 6'b010011, 6'b110010,
                              6'b001011, 6'b101010, 6'b011010, 6'b111010,
                              6'b110011, 6'b100110, 6'b010110, 6'b110110,
                              6'b001110, 6'b101110, 6'b011110, 6'b101011};
        return t[v];
    endfunction

    // Compute the expected symbol (a..j, a as MSB) and queue it
    task automatic push_exp(input logic [7:0] x, input bit k, input string tag);
        logic [4:0] lo = x[4:0];
        logic [2:0] hi = x[7:5];
        logic [5:0] s;
        logic [3:0] f;
        logic [3:0] k28tab[8] = '{4'b0100, 4'b1001, 4'b0101, 4'b0011,
                                  4'b0010, 4'b1010, 4'b0110, 4'b1000};
        logic [3:0] d4[8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                              4'b1101, 4'b1010, 4'b0110, 4'b1110};
        logic rm;
        logic alt;
        logic [9:0] c;
        if (k && lo == 5'd28) begin
            s = mrd ? 6'b110000 : 6'b001111;
            f = mrd ? ~k28tab[hi] : k28tab[hi];
        end else begin
            s = ref6(lo);
            if (mrd && ($countones(s) != 3 || s == 6'b111000)) s = ~s;
            rm = ($countones(s) > 3) ? 1'b1 : ($countones(s) < 3) ? 1'b0 : mrd;
            alt = k || (!rm && (lo == 17 || lo == 18 || lo == 20)) ||
                  (rm && (lo == 11 || lo == 13 || lo == 14));
            f = (hi == 3'd7 && alt) ? 4'b0111 : d4[hi];
            if (rm && ($countones(f) != 2 || f == 4'b1100)) f = ~f;
        end
        c = {s, f};
        if ($countones(c) > 5) mrd = 1'b1;
        else if ($countones(c) < 5) mrd = 1'b0;
        exq.push_back(c);
        tagq.push_back(tag);
    endtask

    // Wait for a capture edge, drive the request and queue its symbol
    task automatic send(input logic [7:0] x, input bit fr, input bit kg,
                        input logic [1:0] kp, input string tag);
        do begin
            @(negedge clk);
            #1;
        end while (!byte_take);
        tx_byte = x; comma_req = fr; k_gen = kg; k_pick = kp;
        if (kg) begin
            case (kp)
                2'b00: push_exp(x, 1'b1, tag);
                2'b01: push_exp(8'h3C, 1'b1, tag);
                2'b10: push_exp(8'h7C, 1'b1, tag);
                default: push_exp(8'hFC, 1'b1, tag);
            endcase
        end else if (fr) push_exp(8'hBC, 1'b1, tag);
        else push_exp(x, 1'b0, tag);
    endtask

    // Line monitor: rebuild 10-bit words from the serial stream
    logic prev_en = 1'b0, prev_take = 1'b0, started = 1'b0, prev_bit = 1'b0, last_bit = 1'b0;
    int idx = 0, en_cnt = 0, run = 0, max_run = 0, words = 0;
    logic [9:0] w = '0;
    always @(negedge clk) begin
        logic bv;
        logic [9:0] e;
        string t;
        #2;
        bv = line_o | wrap_o;
        if (rst_n) begin
            if (wrap_en) check(line_o == 1'b0, "R9 line held in wrap", line_o, 0);
            else         check(wrap_o == 1'b0, "R9 wrap idle", wrap_o, 0);
            if (prev_en) begin
                if (prev_take) begin
                    if (started) check(en_cnt == 10, "R2 capture period", en_cnt, 10);
                    started = 1'b1; idx = 0; en_cnt = 1; w = '0;
                end else begin
                    idx++; en_cnt++;
                end
                if (started) begin
                    w = {w[8:0], bv};
                    run = (bv == last_bit) ? run + 1 : 1;
                    last_bit = bv;
                    if (run > max_run) max_run = run;
                    if (idx == 9) begin
                        if (exq.size() == 0) begin
                            check(1'b0, "R2 unexpected symbol", w, 0);
                        end else begin
                            e = exq.pop_front();
                            t = tagq.pop_front();
                            check(w == e, t, w, e);
                            if (words == 0) check(w == 10'b0011111010, "R1 first comma", w, 10'b0011111010);
                            words++;
                        end
                    end
                end
            end else if (started) begin
                check(bv == prev_bit, "R8 hold without enable", bv, prev_bit);
            end
            prev_bit = bv;
        end
        prev_en = bit_en;
        prev_take = byte_take;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        push_exp(8'hBC, 1'b1, "R1 reset comma");
        repeat (4) @(negedge clk);
        #1;
        check(line_o == 1'b0, "R1 line in reset", line_o, 0);
        check(wrap_o == 1'b0, "R1 wrap in reset", wrap_o, 0);
        check(byte_take == 1'b0, "R1 take in reset", byte_take, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R3: every data byte
        for (int v = 0; v < 256; v++) send(v[7:0], 1'b0, 1'b0, 2'b00, "R3 data byte");
        // R5: byte-valued control characters, framing strobe also set
        for (int y = 0; y < 8; y++) send({y[2:0], 5'd28}, 1'b1, 1'b1, 2'b00, "R5 K28 from byte");
        send(8'hF7, 1'b1, 1'b1, 2'b00, "R5 K23.7");
        send(8'hFB, 1'b0, 1'b1, 2'b00, "R5 K27.7");
        send(8'hFD, 1'b1, 1'b1, 2'b00, "R5 K29.7");
        send(8'hFE, 1'b0, 1'b1, 2'b00, "R5 K30.7");
        // R6: fixed control characters, data and strobe ignored
        for (int j = 0; j < 18; j++)
            send(8'(j * 17), j[0], 1'b1, 2'(1 + (j % 3)), "R6 fixed K");
        // R4: commas mixed with data under both disparities
        for (int j = 0; j < 40; j++)
            send(8'(j * 29 + 3), j[0] | j[1], 1'b0, 2'b00, "R4 comma");
        // R7 and R8: every byte again under a gated enable
        gate_mode = 1'b1;
        for (int v = 0; v < 256; v++)
            send(8'(v * 37 + 11), 1'b0, (v % 9) == 0, 2'b00, "R7 gated disparity");
        gate_mode = 1'b0;
        // R9: loopback path
        wrap_en = 1'b1;
        for (int j = 0; j < 30; j++) send(8'(j * 53), j == 5, 1'b0, 2'b00, "R9 wrapped stream");
        wrap_en = 1'b0;
        for (int j = 0; j < 4; j++) send(8'hBC, 1'b1, 1'b0, 2'b00, "R4 trailing comma");
        repeat (25) @(negedge clk);
        check(max_run == 5, "R10 longest run", max_run, 5);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule